// File: doc/BRIEF.md
# Parallel Smart-LCD Bus Master

This block is the host-side master for an asynchronous 8080-style parallel bus that connects to the register file of a smart display controller. It accepts one request at a time from a valid/ready host port. The four request kinds are an index (command) write, a data write, a full register write, and a register read. A full register write is an index phase followed by a value phase. A read is an index phase, then a bus turnaround, then a strobed read of the panel's answer.

The panel bus is 18 bits wide, but the payloads are 16 bits. The block spreads each payload across the bus with two dead bit lanes, at bus bits 0 and 9. It gathers incoming samples back the same way. The tristate data bus is brought out as separate output, output-enable and input vectors, so the pad ring can form the bidirectional pin.

All bus intervals are counted in clocks. Setup and hold lengths are kept separately for index phases and data phases. A single gap count paces the chip-select, register-select and read-strobe steps. A value of zero in any of these counts is treated as one clock.

Top module: `lcd_bus_master`

## Requirements
- R1: After reset and whenever no request is in progress, `lcd_cs_n`, `lcd_rs`, `lcd_wr_n` and `lcd_rd_n` are high, `lcd_data_oe` is low, `busy` is low and `rd_valid` is low.
- R2: A driven 16-bit payload `v` appears on `lcd_data_o` with `v[7:0]` on bits 8..1 and `v[15:8]` on bits 17..10. Bits 0 and 9 are zero. `lcd_data_o` is zero while `lcd_data_oe` is low.
- R3: Every write phase runs four steps, counted from the cycle after acceptance. First, register-select takes the phase level for G clocks while chip select stays high. Next, chip select is low for G clocks. Then `lcd_wr_n` is low with the bus driven for S clocks. Then `lcd_wr_n` is high with the bus still driven for H clocks.
- R4: `req_op` encodes 0 = index write (carries `req_index`), 1 = data write (carries `req_value`), 2 = register write, 3 = register read. Register-select is low in index phases and high in data phases.
- R5: Index phases use the command setup/hold counts, and data phases use the data setup/hold counts. The reset values are command setup 2, command hold 2, data setup 1, data hold 2 and gap 1. A programmed zero acts as 1.
- R6: A register read performs an index phase. The bus is then released for G clocks with register-select still low. Register-select then rises for G clocks. `lcd_rd_n` is then low for G clocks, and is then high for G clocks before completion.
- R7: `lcd_data_oe` is low in the clock before `lcd_rd_n` falls and stays low while `lcd_rd_n` is low.
- R8: Read data is the bus value in the last clock of `lcd_rd_n` low, with bits 8..1 placed in result 7..0 and bits 17..10 placed in result 15..8. It is shown on `rd_data` with `rd_valid` high for exactly one clock, and this happens once per read.
- R9: `req_ready` equals the inverse of `busy`. A request is accepted only on a clock where it is high. Every request ends with one clock in which chip select is high and `busy` is still high, and then `busy` falls.
- R10: A timing update (`tim_we`) takes effect only while idle. An update in the same clock as an accepted request already governs that request. An update while busy is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tim_we | input | 1 | Load the timing counts below |
| cfg_cmd_setup | input | TW | Strobe-low length for index phases |
| cfg_cmd_hold | input | TW | Post-strobe hold for index phases |
| cfg_dat_setup | input | TW | Strobe-low length for data phases |
| cfg_dat_hold | input | TW | Post-strobe hold for data phases |
| cfg_gap | input | TW | Length of each select/turnaround/read step |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 2 | Request kind (see R4) |
| req_index | input | DW | Register number |
| req_value | input | DW | Value to write |
| busy | output | 1 | Transaction in progress |
| rd_data | output | DW | Read result |
| rd_valid | output | 1 | One-clock read result strobe |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_rs | output | 1 | Register select: low index, high data |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read enable, active low |
| lcd_data_o | output | DW+2 | Bus value to drive |
| lcd_data_oe | output | 1 | Bus drive enable |
| lcd_data_i | input | DW+2 | Bus value seen at the pins |

## Verification
Two events can fall in the same clock: a timing reload and the acceptance of a request. The bench provokes this by raising `tim_we` together with `req_valid` while idle. It then judges the whole bus trace of that request against lengths built from the new counts. A reload pulsed in the middle of a transaction is the converse case. It must leave both the running trace and the next request on the old counts. The panel model answers with the dead lanes set as well as random data, so the read path is judged on dropping bits 0 and 9.

// File: rtl/lcd_bus_master.sv
module lcd_bus_master #(
  parameter int TW            = 4,
  parameter int DW            = 16,
  parameter int DEF_CMD_SETUP = 2,
  parameter int DEF_CMD_HOLD  = 2,
  parameter int DEF_DAT_SETUP = 1,
  parameter int DEF_DAT_HOLD  = 2,
  parameter int DEF_GAP       = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tim_we,
  input  logic [TW-1:0] cfg_cmd_setup,
  input  logic [TW-1:0] cfg_cmd_hold,
  input  logic [TW-1:0] cfg_dat_setup,
  input  logic [TW-1:0] cfg_dat_hold,
  input  logic [TW-1:0] cfg_gap,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [DW-1:0] req_index,
  input  logic [DW-1:0] req_value,
  output logic          busy,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          lcd_cs_n,
  output logic          lcd_rs,
  output logic          lcd_wr_n,
  output logic          lcd_rd_n,
  output logic [DW+1:0] lcd_data_o,
  output logic          lcd_data_oe,
  input  logic [DW+1:0] lcd_data_i
);
  localparam int HB = DW / 2;
  localparam logic [1:0] OP_CMD = 2'd0, OP_DAT = 2'd1, OP_REG = 2'd2, OP_RD = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_SEL, S_STB, S_HLD, S_TURN, S_RSH, S_RDL, S_RDH, S_DONE
  } st_t;

  st_t           st;
  logic [TW-1:0] cnt;
  logic [1:0]    op_q;
  logic          phase_q, rs_q;
  logic [DW-1:0] idx_q, val_q, rd_q;
  logic [TW-1:0] t_cs, t_ch, t_ds, t_dh, t_gap;
  logic [TW-1:0] n_cs, n_ch, n_ds, n_dh, n_gap;
  logic          tim_take;
  logic [DW-1:0] act;

  function automatic logic [TW-1:0] lenm1(input logic [TW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  assign tim_take = tim_we && (st == S_IDLE);
  assign n_cs  = tim_take ? cfg_cmd_setup : t_cs;
  assign n_ch  = tim_take ? cfg_cmd_hold  : t_ch;
  assign n_ds  = tim_take ? cfg_dat_setup : t_ds;
  assign n_dh  = tim_take ? cfg_dat_hold  : t_dh;
  assign n_gap = tim_take ? cfg_gap       : t_gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_cs  <= TW'(DEF_CMD_SETUP);
      t_ch  <= TW'(DEF_CMD_HOLD);
      t_ds  <= TW'(DEF_DAT_SETUP);
      t_dh  <= TW'(DEF_DAT_HOLD);
      t_gap <= TW'(DEF_GAP);
    end else if (tim_take) begin
      t_cs  <= cfg_cmd_setup;
      t_ch  <= cfg_cmd_hold;
      t_ds  <= cfg_dat_setup;
      t_dh  <= cfg_dat_hold;
      t_gap <= cfg_gap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      op_q    <= OP_CMD;
      phase_q <= 1'b0;
      rs_q    <= 1'b1;
      idx_q   <= '0;
      val_q   <= '0;
      rd_q    <= '0;
    end else if (st == S_IDLE) begin
      if (req_valid) begin
        op_q    <= req_op;
        idx_q   <= req_index;
        val_q   <= req_value;
        phase_q <= (req_op == OP_DAT);
        rs_q    <= (req_op == OP_DAT);
        cnt     <= lenm1(n_gap);
        st      <= S_PRE;
      end
    end else if (st == S_DONE) begin
      st <= S_IDLE;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      unique case (st)
        S_PRE: begin st <= S_SEL; cnt <= lenm1(n_gap); end
        S_SEL: begin st <= S_STB; cnt <= lenm1(phase_q ? n_ds : n_cs); end
        S_STB: begin st <= S_HLD; cnt <= lenm1(phase_q ? n_dh : n_ch); end
        S_HLD: begin
          cnt <= lenm1(n_gap);
          if (op_q == OP_REG && !phase_q) begin
            phase_q <= 1'b1;
            rs_q    <= 1'b1;
            st      <= S_PRE;
          end else if (op_q == OP_RD) begin
            st <= S_TURN;
          end else begin
            rs_q <= 1'b1;
            st   <= S_DONE;
          end
        end
        S_TURN: begin st <= S_RSH; rs_q <= 1'b1; cnt <= lenm1(n_gap); end
        S_RSH:  begin st <= S_RDL; cnt <= lenm1(n_gap); end
        S_RDL:  begin
          st   <= S_RDH;
          cnt  <= lenm1(n_gap);
          rd_q <= {lcd_data_i[DW+1:HB+2], lcd_data_i[HB:1]};
        end
        S_RDH:  st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign act         = phase_q ? val_q : idx_q;
  assign busy        = (st != S_IDLE);
  assign req_ready   = !busy;
  assign lcd_cs_n    = (st == S_IDLE) || (st == S_PRE) || (st == S_DONE);
  assign lcd_rs      = rs_q;
  assign lcd_wr_n    = (st != S_STB);
  assign lcd_rd_n    = (st != S_RDL);
  assign lcd_data_oe = (st == S_STB) || (st == S_HLD);
  assign lcd_data_o  = lcd_data_oe ? {act[DW-1:HB], 1'b0, act[HB-1:0], 1'b0} : '0;
  assign rd_valid    = (st == S_DONE) && (op_q == OP_RD);
  assign rd_data     = rd_q;
endmodule

// File: rtl/lcd_bus_master_sva.sv
module lcd_bus_master_sva #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          req_valid,
  input logic          req_ready,
  input logic          lcd_cs_n,
  input logic          lcd_wr_n,
  input logic          lcd_rd_n,
  input logic          lcd_data_oe,
  input logic [DW+1:0] lcd_data_o,
  input logic          rd_valid
);
  localparam int GAPHI = DW / 2 + 1;

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lcd_cs_n && lcd_wr_n && lcd_rd_n && !lcd_data_oe && !rd_valid));

  p_dead_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_data_oe |-> (!lcd_data_o[0] && !lcd_data_o[GAPHI]));

  p_strobe_in_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_wr_n || lcd_data_oe || !lcd_rd_n) |-> !lcd_cs_n);

  p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_rd_n) |-> (!lcd_data_oe && !$past(lcd_data_oe)));

  p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_rd_n |-> !lcd_data_oe);

  p_single_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  p_end_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(lcd_cs_n));
endmodule

bind lcd_bus_master lcd_bus_master_sva #(.DW(DW)) u_sva (
  .clk(clk), .rst_n(rst_n), .busy(busy), .req_valid(req_valid),
  .req_ready(req_ready), .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n),
  .lcd_rd_n(lcd_rd_n), .lcd_data_oe(lcd_data_oe), .lcd_data_o(lcd_data_o),
  .rd_valid(rd_valid)
);

// File: tb/lcd_bus_master_tb_top.sv
`timescale 1ns/1ps
module lcd_bus_master_tb_top;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic tim_we = 0;
  logic [3:0] c_cs = 0, c_ch = 0, c_ds = 0, c_dh = 0, c_g = 0;
  logic req_valid = 0, req_ready, busy, rd_valid;
  logic [1:0] req_op = 0;
  logic [15:0] req_index = 0, req_value = 0, rd_data;
  logic lcd_cs_n, lcd_rs, lcd_wr_n, lcd_rd_n, lcd_data_oe;
  logic [17:0] lcd_data_o, lcd_data_i, rd_raw = 0;

  assign lcd_data_i = lcd_rd_n ? 18'h0 : rd_raw;

  lcd_bus_master dut_i (
    .clk(clk), .rst_n(rst_n), .tim_we(tim_we),
    .cfg_cmd_setup(c_cs), .cfg_cmd_hold(c_ch), .cfg_dat_setup(c_ds),
    .cfg_dat_hold(c_dh), .cfg_gap(c_g),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_index(req_index), .req_value(req_value), .busy(busy),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .lcd_cs_n(lcd_cs_n), .lcd_rs(lcd_rs), .lcd_wr_n(lcd_wr_n),
    .lcd_rd_n(lcd_rd_n), .lcd_data_o(lcd_data_o), .lcd_data_oe(lcd_data_oe),
    .lcd_data_i(lcd_data_i)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  int m_cs = 2, m_ch = 2, m_ds = 1, m_dh = 2, m_g = 1;
  logic [22:0] expq[$];
  logic [22:0] gotq[$];

  function automatic logic [17:0] pk(input logic [15:0] v);
    return {v[15:8], 1'b0, v[7:0], 1'b0};
  endfunction
  function automatic logic [15:0] up(input logic [17:0] b);
    return {b[17:10], b[8:1]};
  endfunction
  function automatic int ef(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic add(input int n, input logic [22:0] e);
    for (int i = 0; i < n; i++) expq.push_back(e);
  endtask

  task automatic phase(input logic rs, input logic [15:0] v, input int s, input int h);
    add(ef(m_g), {1'b1, rs, 1'b1, 1'b1, 1'b0, 18'h0});
    add(ef(m_g), {1'b0, rs, 1'b1, 1'b1, 1'b0, 18'h0});
    add(ef(s),   {1'b0, rs, 1'b0, 1'b1, 1'b1, pk(v)});
    add(ef(h),   {1'b0, rs, 1'b1, 1'b1, 1'b1, pk(v)});
  endtask

  task automatic build(input logic [1:0] op, input logic [15:0] idx, input logic [15:0] val);
    expq.delete();
    if (op != 2'd1) phase(1'b0, idx, m_cs, m_ch);
    if (op == 2'd1 || op == 2'd2) phase(1'b1, val, m_ds, m_dh);
    if (op == 2'd3) begin
      add(ef(m_g), {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 18'h0});
      add(ef(m_g), {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 18'h0});
      add(ef(m_g), {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 18'h0});
      add(ef(m_g), {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 18'h0});
    end
    add(1, {1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 18'h0});
  endtask

  // upd: timing load in the accept cycle; poke: junk timing load while busy
  task automatic xact(input logic [1:0] op, input logic [15:0] idx, input logic [15:0] val,
                      input bit upd, input int ncs, input int nch, input int nds, input int ndh,
                      input int ng, input bit poke, input string tag);
    int nvalid = 0, notready = 0, k = 0, bad = -1;
    logic [15:0] got_rd = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_op = op; req_index = idx; req_value = val;
    if (upd) begin
      tim_we = 1; c_cs = 4'(ncs); c_ch = 4'(nch); c_ds = 4'(nds); c_dh = 4'(ndh); c_g = 4'(ng);
      m_cs = ncs; m_ch = nch; m_ds = nds; m_dh = ndh; m_g = ng;
    end
    build(op, idx, val);
    @(negedge clk);
    req_valid = 0; tim_we = 0;
    gotq.delete();
    while (busy) begin
      gotq.push_back({lcd_cs_n, lcd_rs, lcd_wr_n, lcd_rd_n, lcd_data_oe, lcd_data_o});
      if (req_ready) notready++;
      if (rd_valid) begin nvalid++; got_rd = rd_data; end
      if (poke && k == 2) begin
        tim_we = 1; c_cs = 4'd9; c_ch = 4'd9; c_ds = 4'd9; c_dh = 4'd9; c_g = 4'd9;
      end else tim_we = 0;
      k++;
      @(negedge clk);
    end
    tim_we = 0;
    foreach (expq[i]) if (bad < 0 && (i >= gotq.size() || gotq[i] != expq[i])) bad = i;
    if (gotq.size() != expq.size() && bad < 0) bad = expq.size();
    chk(bad < 0, {tag, " R2/R3/R4/R5/R6/R10 bus trace"},
        (bad >= 0 && bad < gotq.size()) ? 32'(gotq[bad]) : 32'(gotq.size()),
        (bad >= 0 && bad < expq.size()) ? 32'(expq[bad]) : 32'(expq.size()));
    chk(notready == 0, {tag, " R9 ready low while busy"}, notready, 0);
    chk(nvalid == (op == 2'd3 ? 1 : 0), {tag, " R8 rd_valid count"}, nvalid, op == 2'd3);
    if (op == 2'd3) chk(got_rd == up(rd_raw), {tag, " R8 read data"}, got_rd, up(rd_raw));
    chk(!lcd_data_oe && lcd_cs_n && lcd_wr_n && lcd_rd_n && lcd_rs, {tag, " R1 idle after"},
        {lcd_cs_n, lcd_rs, lcd_wr_n, lcd_rd_n, lcd_data_oe}, 5'b11110);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1));
    repeat (3) @(negedge clk);
    chk(!busy && req_ready && !rd_valid && lcd_cs_n && lcd_rs && lcd_wr_n && lcd_rd_n && !lcd_data_oe,
        "R1 reset state", {busy, lcd_cs_n, lcd_rs, lcd_wr_n, lcd_rd_n, lcd_data_oe}, 6'b011110);
    rst_n = 1;
    // R5 reset defaults, R4 each op
    xact(2'd0, 16'h00E5, 0, 0, 0, 0, 0, 0, 0, 0, "default index");
    xact(2'd1, 0, 16'h78F0, 0, 0, 0, 0, 0, 0, 0, "default data");
    xact(2'd2, 16'h0010, 16'h1290, 0, 0, 0, 0, 0, 0, 0, "default regwr");
    // R2 dead lanes with all-ones payload
    xact(2'd2, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0, "ones R2");
    // R8 read: lanes 0 and 9 set must drop
    rd_raw = 18'h3FFFF;
    xact(2'd3, 16'h0000, 0, 0, 0, 0, 0, 0, 0, 0, "read ones");
    rd_raw = 18'h00201;
    xact(2'd3, 16'h0001, 0, 0, 0, 0, 0, 0, 0, 0, "read lanes only");
    // R5 zero counts behave as one; R10 same-cycle load
    xact(2'd3, 16'h1234, 0, 1, 0, 0, 0, 0, 0, 0, "zeros same-cycle R10");
    xact(2'd2, 16'h0029, 16'h0014, 1, 3, 1, 4, 2, 3, 0, "same-cycle load R10");
    // R10 load while busy discarded (trace of this and next keep old counts)
    xact(2'd2, 16'h0060, 16'hA700, 0, 0, 0, 0, 0, 0, 1, "busy poke R10");
    xact(2'd3, 16'h0007, 0, 0, 0, 0, 0, 0, 0, 0, "after poke R10");
    for (int n = 0; n < 80; n++) begin
      bit u = ($urandom_range(0, 3) == 0);
      rd_raw = 18'($urandom);
      xact(2'($urandom_range(0, 3)), 16'($urandom), 16'($urandom), u,
           $urandom_range(0, 4), $urandom_range(0, 4), $urandom_range(0, 4),
           $urandom_range(0, 4), $urandom_range(0, 3), ($urandom_range(0, 4) == 0), "random");
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule